// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the power-control bits of a small peripheral device and decides which of three power states the device is in. In the operational state the fast clock runs. In sleep only the 32 kHz clock runs. In hibernate no clock runs at all. The block drives an enable for the fast oscillator and an enable for the slow clock. It also drives three per-module clock enables, for the GPIO, keypad and PWM units, and a one-cycle soft-reset request.

Software moves the device down through a small register port. A sleep-request bit clears itself once sleep is reached. A hibernate bit drops the device into hibernate. A self-clearing reset bit returns every register to its reset value. The device can also fall asleep by itself. A timer counts 32 kHz ticks in the operational state and is restarted only by a completed bus transaction addressed to this device. The way back up depends on the state. Sleep wakes on an addressed transaction, the wake-up pin or an interrupt event. Hibernate wakes only on an addressed transaction. A keypress in hibernate moves the device into sleep while an external debouncer judges the key. A valid key keeps the device asleep. An invalid key sends it back into hibernate.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `pwrState` is 0 (operational), register 0 reads 0x0F, register 1 reads 0x00, `modEn` is 3'b111, `fastOscEn` and `slowClkEn` are 1, and `softRstPulse` and `extClkSel` are 0.
- R2: Register 0 maps bit 3 to `modEn[2]` (GPIO), bit 1 to `modEn[1]` (keypad), bit 0 to `modEn[0]` (PWM) and bit 6 to `extClkSel`. Bit 2 always reads 1 and ignores writes.
- R3: A write of register 0 with bit 7 set puts all registers back to their reset values and the state back to 0 at that clock edge. `softRstPulse` is 1 for exactly the following cycle, and bit 7 reads 0.
- R4: Writing 1 to register 0 bit 4 in the operational state makes `pwrState` read 1 (sleep) from the second edge on. Bit 4 then reads 0, `fastOscEn` is 0, `slowClkEn` is 1, and `modEn` still follows its bits.
- R5: In sleep, a pulse on `addrHit`, `wakePin` or `irqEvent` returns `pwrState` to 0 at the next edge.
- R6: Writing 1 to register 0 bit 5 makes `pwrState` read 2 (hibernate) from the second edge on, with `modEn`, `fastOscEn` and `slowClkEn` all 0.
- R7: In hibernate, `wakePin` and `irqEvent` have no effect. `addrHit` returns the state to 0 at the next edge and clears bit 5.
- R8: In hibernate, `keyDetect` moves `pwrState` to 1 at the next edge. Then `dbDone` with `dbValid`=0 returns it to 2. `dbDone` with `dbValid`=1 keeps it at 1, clears bit 5, and a later wake event returns it to 0.
- R9: With register 1 bit 3 set and delay code c in bits 2:0, the device goes from operational to sleep on the N-th `tick32k` pulse, where N = TICKS_PER_MS x (4 if c is 0, else 8 << c).
- R10: An `addrHit` pulse restarts the auto-sleep count from zero. With register 1 bit 3 clear, the device never leaves the operational state on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 control, 1 auto-sleep setup |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read select |
| rdData | output | 8 | Read data of the selected register |
| tick32k | input | 1 | One-cycle pulse per 32 kHz period |
| addrHit | input | 1 | Completed bus transaction addressed to this device |
| wakePin | input | 1 | Wake-up pin event |
| irqEvent | input | 1 | Keypad or hotkey interrupt event |
| keyDetect | input | 1 | Keypress seen while hibernating |
| dbDone | input | 1 | Debounce verdict strobe |
| dbValid | input | 1 | Debounce verdict: 1 valid key |
| pwrState | output | 2 | 0 operational, 1 sleep, 2 hibernate |
| modEn | output | 3 | Clock enables {GPIO, keypad, PWM} |
| fastOscEn | output | 1 | Fast oscillator enable |
| slowClkEn | output | 1 | 32 kHz clock enable |
| extClkSel | output | 1 | Select external 32 kHz source |
| softRstPulse | output | 1 | One-cycle soft reset request |

## Verification
A wrong state register shows up on `pwrState` and on the clock enables within one edge of the event that should have moved it. That includes a key-debounce detour that never resolves and a hibernate that ignores its wake. A self-clearing bit that fails to clear shows up at the wake after it: the device falls straight back into sleep or hibernate, and the readback still shows the bit. An auto-sleep counter with a wrong limit or a missed restart moves the sleep transition off its expected tick. The tick counts are chosen to make that visible on the exact pulse.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_OPER   = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_HIB    = 2'd2,
    ST_KEYCHK = 2'd3
  } pwrSt_e;

  typedef struct packed {
    logic clrSleep;
    logic clrHib;
    logic cntRun;
  } ctrlStb_t;

  localparam int MS_W = 11;

  function automatic logic [MS_W-1:0] delayMs(input logic [2:0] code);
    if (code == 3'd0) return MS_W'(4);
    return MS_W'(MS_W'(8) << code);
  endfunction

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int TICKS_PER_MS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       rdAddr,
  input  logic       tick32k,
  input  logic       addrHit,
  input  ctrlStb_t   stb,
  output logic [7:0] rdData,
  output logic       sleepReq,
  output logic       hibReq,
  output logic       swRst,
  output logic       autoTo,
  output logic [2:0] rawEn,
  output logic       extSel,
  output logic       rstPulse
);

  localparam int MAX_TICKS = 1024 * TICKS_PER_MS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             sleepBit, hibBit, gpioBit, keyBit, pwmBit;
  logic             autoEn;
  logic [2:0]       dlyCode;
  logic [CNT_W-1:0] cnt, limit;

  assign swRst = wrEn && !wrAddr && wrData[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPulse <= 1'b0;
      extSel   <= 1'b0;
      hibBit   <= 1'b0;
      sleepBit <= 1'b0;
      gpioBit  <= 1'b1;
      keyBit   <= 1'b1;
      pwmBit   <= 1'b1;
      autoEn   <= 1'b0;
      dlyCode  <= 3'd0;
    end else begin
      rstPulse <= swRst;
      if (swRst) begin
        extSel   <= 1'b0;
        hibBit   <= 1'b0;
        sleepBit <= 1'b0;
        gpioBit  <= 1'b1;
        keyBit   <= 1'b1;
        pwmBit   <= 1'b1;
        autoEn   <= 1'b0;
        dlyCode  <= 3'd0;
      end else begin
        if (wrEn && !wrAddr) begin
          extSel   <= wrData[6];
          hibBit   <= wrData[5];
          sleepBit <= wrData[4];
          gpioBit  <= wrData[3];
          keyBit   <= wrData[1];
          pwmBit   <= wrData[0];
        end
        if (wrEn && wrAddr) begin
          autoEn  <= wrData[3];
          dlyCode <= wrData[2:0];
        end
        if (stb.clrSleep) sleepBit <= 1'b0;
        if (stb.clrHib)   hibBit   <= 1'b0;
      end
    end
  end

  assign limit  = CNT_W'(32'(delayMs(dlyCode)) * TICKS_PER_MS);
  assign autoTo = stb.cntRun && autoEn && tick32k && !addrHit && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (swRst || !stb.cntRun || !autoEn || addrHit) begin
      cnt <= '0;
    end else if (tick32k) begin
      cnt <= autoTo ? '0 : cnt + CNT_W'(1);
    end
  end

  assign sleepReq = sleepBit;
  assign hibReq   = hibBit;
  assign rawEn    = {gpioBit, keyBit, pwmBit};
  assign rdData   = rdAddr ? {4'b0000, autoEn, dlyCode}
                           : {1'b0, extSel, hibBit, sleepBit, gpioBit, 1'b1, keyBit, pwmBit};

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swRst,
  input  logic       sleepReq,
  input  logic       hibReq,
  input  logic       autoTo,
  input  logic       addrHit,
  input  logic       wakePin,
  input  logic       irqEvent,
  input  logic       keyDetect,
  input  logic       dbDone,
  input  logic       dbValid,
  output ctrlStb_t   stb,
  output logic [1:0] pwrState,
  output logic       fastOscEn,
  output logic       slowClkEn
);

  pwrSt_e st, stNext;

  always_comb begin
    stNext       = st;
    stb.clrSleep = 1'b0;
    stb.clrHib   = 1'b0;
    stb.cntRun   = (st == ST_OPER);
    unique case (st)
      ST_OPER: begin
        if (hibReq) begin
          stNext       = ST_HIB;
          stb.clrSleep = sleepReq;
        end else if (sleepReq || autoTo) begin
          stNext       = ST_SLEEP;
          stb.clrSleep = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (addrHit || wakePin || irqEvent) stNext = ST_OPER;
        else if (hibReq)                    stNext = ST_HIB;
      end
      ST_KEYCHK: begin
        if (addrHit) begin
          stNext     = ST_OPER;
          stb.clrHib = 1'b1;
        end else if (dbDone) begin
          stNext     = dbValid ? ST_SLEEP : ST_HIB;
          stb.clrHib = dbValid;
        end
      end
      ST_HIB: begin
        if (addrHit) begin
          stNext     = ST_OPER;
          stb.clrHib = 1'b1;
        end else if (keyDetect) begin
          stNext = ST_KEYCHK;
        end
      end
      default: stNext = ST_OPER;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      st <= ST_OPER;
    else if (swRst) st <= ST_OPER;
    else            st <= stNext;
  end

  assign pwrState  = (st == ST_KEYCHK) ? 2'(ST_SLEEP) : 2'(st);
  assign fastOscEn = (st == ST_OPER);
  assign slowClkEn = (st != ST_HIB);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int TICKS_PER_MS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       rdAddr,
  output logic [7:0] rdData,
  input  logic       tick32k,
  input  logic       addrHit,
  input  logic       wakePin,
  input  logic       irqEvent,
  input  logic       keyDetect,
  input  logic       dbDone,
  input  logic       dbValid,
  output logic [1:0] pwrState,
  output logic [2:0] modEn,
  output logic       fastOscEn,
  output logic       slowClkEn,
  output logic       extClkSel,
  output logic       softRstPulse
);

  ctrlStb_t   stb;
  logic       sleepReq, hibReq, swRst, autoTo;
  logic [2:0] rawEn;

  pwr_seq_dp #(.TICKS_PER_MS(TICKS_PER_MS)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .tick32k(tick32k), .addrHit(addrHit), .stb(stb),
    .rdData(rdData), .sleepReq(sleepReq), .hibReq(hibReq), .swRst(swRst),
    .autoTo(autoTo), .rawEn(rawEn), .extSel(extClkSel), .rstPulse(softRstPulse)
  );

  pwr_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .swRst(swRst), .sleepReq(sleepReq), .hibReq(hibReq),
    .autoTo(autoTo), .addrHit(addrHit), .wakePin(wakePin), .irqEvent(irqEvent),
    .keyDetect(keyDetect), .dbDone(dbDone), .dbValid(dbValid), .stb(stb),
    .pwrState(pwrState), .fastOscEn(fastOscEn), .slowClkEn(slowClkEn)
  );

  assign modEn = slowClkEn ? rawEn : 3'b000;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrAddr,
  input logic [7:0] wrData,
  input logic       addrHit,
  input logic       keyDetect,
  input logic [1:0] pwrState,
  input logic       softRstPulse
);

  logic swWr;
  assign swWr = wrEn && !wrAddr && wrData[7];

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3); // R1

  AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse && !swWr |=> !softRstPulse); // R3

  AST_SOFTRST_OPER: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse |-> pwrState == 2'd0); // R3

  AST_SLEEP_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd1 && addrHit |=> pwrState == 2'd0); // R5

  AST_HIB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd2 && !addrHit && !keyDetect && !swWr |=> pwrState == 2'd2); // R7

  AST_HIB_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd2 && addrHit |=> pwrState == 2'd0); // R7

  AST_KEY_DETOUR: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd2 && keyDetect && !addrHit && !swWr |=> pwrState == 2'd1); // R8

endmodule

bind pwr_mode_seq pwr_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .addrHit(addrHit), .keyDetect(keyDetect), .pwrState(pwrState),
  .softRstPulse(softRstPulse)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  // {wrEn, wrAddr, wrData, {addrHit,wakePin,irqEvent,keyDetect,dbDone,dbValid}, expState}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b0,8'h1F,6'b000000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd1},
    {1'b0,1'b0,8'h00,6'b010000,2'd0},
    {1'b1,1'b0,8'h1F,6'b000000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd1},
    {1'b0,1'b0,8'h00,6'b001000,2'd0},
    {1'b1,1'b0,8'h1F,6'b000000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd1},
    {1'b0,1'b0,8'h00,6'b100000,2'd0},
    {1'b1,1'b0,8'h2F,6'b000000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd2},
    {1'b0,1'b0,8'h00,6'b010000,2'd2},
    {1'b0,1'b0,8'h00,6'b001000,2'd2},
    {1'b0,1'b0,8'h00,6'b000100,2'd1},
    {1'b0,1'b0,8'h00,6'b000010,2'd2},
    {1'b0,1'b0,8'h00,6'b000100,2'd1},
    {1'b0,1'b0,8'h00,6'b000011,2'd1},
    {1'b0,1'b0,8'h00,6'b000000,2'd1},
    {1'b0,1'b0,8'h00,6'b010000,2'd0},
    {1'b1,1'b0,8'h2F,6'b000000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd2},
    {1'b0,1'b0,8'h00,6'b100000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd0},
    {1'b1,1'b0,8'h2F,6'b000000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd2},
    {1'b0,1'b0,8'h00,6'b000100,2'd1},
    {1'b0,1'b0,8'h00,6'b100000,2'd0},
    {1'b0,1'b0,8'h00,6'b000000,2'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, wrAddr = 1'b0, rdAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       tick32k = 1'b0, addrHit = 1'b0, wakePin = 1'b0, irqEvent = 1'b0;
  logic       keyDetect = 1'b0, dbDone = 1'b0, dbValid = 1'b0;
  logic [7:0] rdData;
  logic [1:0] pwrState;
  logic [2:0] modEn;
  logic       fastOscEn, slowClkEn, extClkSel, softRstPulse;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.TICKS_PER_MS(1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tick32k(tick32k), .addrHit(addrHit),
    .wakePin(wakePin), .irqEvent(irqEvent), .keyDetect(keyDetect),
    .dbDone(dbDone), .dbValid(dbValid), .pwrState(pwrState), .modEn(modEn),
    .fastOscEn(fastOscEn), .slowClkEn(slowClkEn), .extClkSel(extClkSel),
    .softRstPulse(softRstPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    wrEn = 0; wrAddr = 0; wrData = 0; tick32k = 0; addrHit = 0; wakePin = 0;
    irqEvent = 0; keyDetect = 0; dbDone = 0; dbValid = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    step();
  endtask

  task automatic regRead(input logic a, output logic [7:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick32k = 1;
      step();
    end
  endtask

  task automatic hit();
    addrHit = 1;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    clearIn();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;

    // R1 reset state
    check("R1 state", 32'(pwrState), 0);
    regRead(0, rd); check("R1 reg0", 32'(rd), 32'h0F);
    regRead(1, rd); check("R1 reg1", 32'(rd), 32'h00);
    check("R1 modEn", 32'(modEn), 3'b111);
    check("R1 osc", 32'({fastOscEn, slowClkEn, softRstPulse, extClkSel}), 4'b1100);

    // R4 R5 R6 R7 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      wrEn = VEC[i][17]; wrAddr = VEC[i][16]; wrData = VEC[i][15:8];
      {addrHit, wakePin, irqEvent, keyDetect, dbDone, dbValid} = VEC[i][7:2];
      step();
      check($sformatf("R4/R5/R6/R7/R8 vector %0d", i), 32'(pwrState), 32'(VEC[i][1:0]));
    end

    // R2 enable mapping, external select, reserved bit
    regWrite(0, 8'h48);
    check("R2 modEn", 32'(modEn), 3'b100);
    check("R2 extClkSel", 32'(extClkSel), 1);
    regRead(0, rd); check("R2 readback bit2", 32'(rd), 32'h4C);
    regWrite(0, 8'h0A);
    check("R2 modEn keypad", 32'(modEn), 3'b110);

    // R4 sleep keeps enables, bit clears
    regWrite(0, 8'h11);
    step();
    check("R4 state", 32'(pwrState), 1);
    check("R4 modEn", 32'(modEn), 3'b001);
    check("R4 osc", 32'({fastOscEn, slowClkEn}), 2'b01);
    regRead(0, rd); check("R4 bit4 cleared", 32'(rd), 32'h05);
    hit();
    check("R5 addrHit wake", 32'(pwrState), 0);

    // R6 hibernate gating, R7 bit5 cleared on wake
    regWrite(0, 8'h2F);
    step();
    check("R6 state", 32'(pwrState), 2);
    check("R6 gates", 32'({modEn, fastOscEn, slowClkEn}), 5'b00000);
    hit();
    regRead(0, rd); check("R7 bit5 cleared", 32'(rd), 32'h0F);

    // R3 soft reset
    regWrite(1, 8'h0B);
    regWrite(0, 8'h40);
    regWrite(0, 8'h80);
    check("R3 pulse", 32'(softRstPulse), 1);
    regRead(0, rd); check("R3 reg0", 32'(rd), 32'h0F);
    regRead(1, rd); check("R3 reg1", 32'(rd), 32'h00);
    step();
    check("R3 pulse one cycle", 32'(softRstPulse), 0);
    regWrite(0, 8'h1F);
    step();
    check("R3 pre sleep", 32'(pwrState), 1);
    regWrite(0, 8'h8F);
    check("R3 from sleep", 32'({pwrState, softRstPulse}), 3'b001);

    // R9 auto-sleep code 0: 4 ticks
    regWrite(1, 8'h08);
    ticks(3);
    check("R9 code0 before", 32'(pwrState), 0);
    ticks(1);
    check("R9 code0 at limit", 32'(pwrState), 1);
    hit();

    // R9 code 1: 16 ticks
    regWrite(1, 8'h09);
    ticks(15);
    check("R9 code1 before", 32'(pwrState), 0);
    ticks(1);
    check("R9 code1 at limit", 32'(pwrState), 1);
    hit();

    // R9 code 7: 1024 ticks
    regWrite(1, 8'h0F);
    ticks(1023);
    check("R9 code7 before", 32'(pwrState), 0);
    ticks(1);
    check("R9 code7 at limit", 32'(pwrState), 1);
    hit();

    // R10 restart by addrHit, disabled never sleeps
    regWrite(1, 8'h08);
    ticks(3);
    hit();
    ticks(3);
    check("R10 restart", 32'(pwrState), 0);
    ticks(1);
    check("R10 after restart", 32'(pwrState), 1);
    hit();
    regWrite(1, 8'h00);
    ticks(50);
    check("R10 disabled", 32'(pwrState), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule